// File: doc/BRIEF.md
# Gap-Aligned Measurement Frame Receiver

This block takes the byte stream coming out of a serial receiver and rebuilds it into frames of four 16-bit measurement words: input voltage, input current, output voltage and output current. Each word arrives as two bytes, so a frame is eight bytes long. The sender puts no marker in the stream. The receiver finds the start of a frame from the silence between frames. When the time since the previous byte exceeds a set limit, the next byte is taken as byte zero of a new frame. A dropped or extra byte therefore spoils at most the frame it belongs to.

The timeout is a parameter counted in clock cycles, so half a second can be set for any clock frequency. At 9600 baud, bytes inside a frame come about 1 ms apart and frames come about once a second, which leaves a wide margin on both sides of the limit. A complete frame updates all four result registers together and raises a one-cycle frame-valid pulse. A hold input freezes the registers so they can be read out at leisure. Byte counting continues in the background while the registers are frozen.

Top module: `meas_frame_rx`

## Requirements
- R1: While reset is low, and after it until the first frame completes, all four result outputs are zero and `frame_valid` is low.
- R2: A frame is eight bytes in channel order `in_volt`, `in_curr`, `out_volt`, `out_curr`. Each channel takes two bytes, high byte first. Each result is `{high,low} & 16'h3FFF`, so bits 15:14 are always zero.
- R3: `frame_valid` is high for exactly one cycle, on the clock edge that samples the eighth byte of a frame. All four outputs take their new values on that same edge.
- R4: The result outputs never change except on an edge that also raises `frame_valid`.
- R5: The gap is the number of clock edges between two consecutive byte strobes. If it is greater than `GAP_CYCLES`, the new byte is byte zero of a frame. If it is `GAP_CYCLES` or less, numbering continues. An idle time of any length, however far beyond the limit, has the same effect.
- R6: If a timeout occurs part way through a frame, the partial frame is dropped. The outputs keep their old values and no `frame_valid` is raised.
- R7: While `hold` is high on the edge that completes a frame, that frame is dropped: the outputs keep their values and `frame_valid` stays low. Byte numbering continues, so the next eight bytes still form a frame.
- R8: Frames sent back to back with no gap follow each other. The ninth byte starts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_stb | input | 1 | One-cycle strobe: a received byte is present |
| byte_data | input | 8 | Received byte, valid with `byte_stb` |
| hold | input | 1 | Freeze the result registers |
| in_volt | output | 16 | Channel 0 result |
| in_curr | output | 16 | Channel 1 result |
| out_volt | output | 16 | Channel 2 result |
| out_curr | output | 16 | Channel 3 result |
| frame_valid | output | 1 | One-cycle pulse when the results update |

## Verification
The bench sweeps the inter-byte gap across the timeout edge, from two cycles below the limit to two cycles above it. At a gap equal to the limit, a receiver that resynchronised with `>=` instead of `>` would split the frame in the wrong place and show the wrong words. The bench also breaks off frames after each partial length from one to seven bytes. It waits out very long idle times to catch a counter that wraps instead of saturating. It checks high bytes of `8'hFF` to catch missing masking of the top two bits. Hold tests make sure a frozen frame is dropped rather than delayed, and that byte numbering still moves forward while the registers are frozen.

// File: rtl/meas_frame_pkg.sv
// Shared constants and types for the measurement frame receiver.
// Assumes two bytes per word and words wider than one byte.
package meas_frame_pkg;
    localparam int BYTE_W         = 8;
    localparam int BYTES_PER_WORD = 2;
    localparam int WORD_W         = BYTE_W * BYTES_PER_WORD;
    localparam int NUM_CH         = 4;
    localparam int FRAME_BYTES    = NUM_CH * BYTES_PER_WORD;
    localparam int RESULT_W       = 14;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/meas_gap_timer.sv
// Counts idle cycles since the last byte strobe. It saturates at GAP_CYCLES
// so that idle times of any length are handled. 'stale' is high when the gap
// from the previous strobe to a strobe in the current cycle exceeds
// GAP_CYCLES. Assumes GAP_CYCLES >= 1.
module meas_gap_timer #(
    parameter int GAP_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_stb,
    output logic stale
);
    localparam int CNT_W = $clog2(GAP_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GAP_CYCLES);

    logic [CNT_W-1:0] idle_cnt;

    // Restart on every strobe; otherwise count up to LIMIT and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (byte_stb) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LIMIT) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // After k cycles between strobes idle_cnt equals k-1; gap > LIMIT <=> idle_cnt == LIMIT.
    always_comb stale = (idle_cnt == LIMIT);
endmodule

// File: rtl/meas_frame_asm.sv
// Tracks the byte position within a frame and stores the first
// FRAME_BYTES-1 bytes. On the last byte it presents the complete frame
// (last byte taken straight from the input) together with a done strobe.
// Each word is high byte first, masked to RESULT_W bits.
module meas_frame_asm
    import meas_frame_pkg::*;
#(
    parameter int NCH  = NUM_CH,
    parameter int RES_W = RESULT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_stb,
    input  byte_t                 byte_in,
    input  logic                  resync,
    output logic                  done,
    output logic [NCH-1:0][WORD_W-1:0] words
);
    localparam int NBYTES = NCH * BYTES_PER_WORD;
    localparam int POS_W  = $clog2(NBYTES);
    localparam logic [POS_W-1:0] LAST = POS_W'(NBYTES - 1);
    localparam word_t MASK = word_t'((32'd1 << RES_W) - 1);

    logic [POS_W-1:0] pos, pos_eff;
    byte_t            store [NBYTES-1];
    byte_t            bytes_now [NBYTES];

    // A timeout forces the arriving byte to position zero.
    always_comb pos_eff = resync ? '0 : pos;
    always_comb done = byte_stb && (pos_eff == LAST);

    // Advance the position on each strobe, wrapping after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (byte_stb) begin
            pos <= (pos_eff == LAST) ? '0 : pos_eff + 1'b1;
        end
    end

    genvar i;
    generate
        for (i = 0; i < NBYTES - 1; i++) begin : g_store
            // Capture the byte that belongs to slot i.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store[i] <= '0;
                end else if (byte_stb && pos_eff == POS_W'(i)) begin
                    store[i] <= byte_in;
                end
            end
            always_comb bytes_now[i] = store[i];
        end
    endgenerate

    // The final slot is never stored; it is the byte on the input now.
    always_comb bytes_now[NBYTES-1] = byte_in;

    generate
        for (i = 0; i < NCH; i++) begin : g_word
            // Join the high and low bytes and drop the unused top bits.
            always_comb words[i] = {bytes_now[2*i], bytes_now[2*i+1]} & MASK;
        end
    endgenerate
endmodule

// File: rtl/meas_result_hold.sv
// Result registers. Loads all channels together when a frame completes and
// hold is low, and pulses 'valid' for that one cycle. A frame that completes
// under hold is dropped.
module meas_result_hold
    import meas_frame_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       hold,
    input  logic [NCH-1:0][WORD_W-1:0] words_in,
    output logic [NCH-1:0][WORD_W-1:0] words_out,
    output logic                       valid
);
    // Update the registers and raise the pulse only for an unfrozen completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_out <= '0;
            valid     <= 1'b0;
        end else begin
            valid <= load && !hold;
            if (load && !hold) begin
                words_out <= words_in;
            end
        end
    end
endmodule

// File: rtl/meas_frame_rx.sv
// Top level: rebuilds four-channel measurement frames from a byte stream,
// realigning to frame boundaries on inter-byte silence longer than
// GAP_CYCLES clock cycles. Assumes byte_stb is a single-cycle strobe.
module meas_frame_rx
    import meas_frame_pkg::*;
#(
    parameter int GAP_CYCLES = 25_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_stb,
    input  logic [7:0]  byte_data,
    input  logic        hold,
    output logic [15:0] in_volt,
    output logic [15:0] in_curr,
    output logic [15:0] out_volt,
    output logic [15:0] out_curr,
    output logic        frame_valid
);
    logic                          stale;
    logic                          done;
    logic [NUM_CH-1:0][WORD_W-1:0] frame_words;
    logic [NUM_CH-1:0][WORD_W-1:0] result_words;

    meas_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_stb (byte_stb),
        .stale    (stale)
    );

    meas_frame_asm #(.NCH(NUM_CH), .RES_W(RESULT_W)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_stb (byte_stb),
        .byte_in  (byte_data),
        .resync   (stale),
        .done     (done),
        .words    (frame_words)
    );

    meas_result_hold #(.NCH(NUM_CH)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (done),
        .hold      (hold),
        .words_in  (frame_words),
        .words_out (result_words),
        .valid     (frame_valid)
    );

    // Channel order on the ports follows word order in the frame.
    always_comb begin
        in_volt  = result_words[0];
        in_curr  = result_words[1];
        out_volt = result_words[2];
        out_curr = result_words[3];
    end
endmodule

// File: rtl/meas_frame_rx_chk.sv
// Property checker for meas_frame_rx, attached with bind.
module meas_frame_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        byte_stb,
    input logic        hold,
    input logic [15:0] in_volt,
    input logic [15:0] in_curr,
    input logic [15:0] out_volt,
    input logic [15:0] out_curr,
    input logic        frame_valid
);
    logic [63:0] all_out;
    always_comb all_out = {in_volt, in_curr, out_volt, out_curr};

    AST_RESULT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_volt[15:14] == 2'b00) && (in_curr[15:14] == 2'b00) &&
        (out_volt[15:14] == 2'b00) && (out_curr[15:14] == 2'b00)); // R2

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R3

    AST_VALID_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(byte_stb)); // R3

    AST_CHANGE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(all_out) |-> frame_valid); // R4

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(all_out)); // R7

    AST_FROZEN_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !frame_valid); // R7
endmodule

bind meas_frame_rx meas_frame_rx_chk u_chk (.*);

// File: tb/meas_frame_rx_test.sv
module meas_frame_rx_test;
    localparam int PERIOD = 10;
    localparam int GAP    = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        hold = 1'b0;
    logic [15:0] in_volt, in_curr, out_volt, out_curr;
    logic        frame_valid;

    int total = 0;
    int bad   = 0;

    // Bench reference model state, derived from the requirements.
    logic [7:0]  mbuf [8];
    int          mpos = 0;
    int          since = 0;
    logic [15:0] exp_o [4] = '{16'h0, 16'h0, 16'h0, 16'h0};
    logic        exp_v = 1'b0;

    meas_frame_rx #(.GAP_CYCLES(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_data(byte_data),
        .hold(hold), .in_volt(in_volt), .in_curr(in_curr), .out_volt(out_volt),
        .out_curr(out_curr), .frame_valid(frame_valid)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        logic [63:0] act, exp;
        act = {in_volt, in_curr, out_volt, out_curr};
        exp = {exp_o[0], exp_o[1], exp_o[2], exp_o[3]};
        chk(act == exp, req, "outputs", act, exp);
        chk(frame_valid == exp_v, req, "frame_valid", 64'(frame_valid), 64'(exp_v));
    endtask

    // Send one byte in one cycle; called and returning at a falling edge.
    task automatic put(input logic [7:0] b, input string req);
        bit done;
        if (since + 1 > GAP) mpos = 0;   // R5: gap greater than limit resyncs
        mbuf[mpos] = b;
        done = (mpos == 7);
        mpos = done ? 0 : mpos + 1;
        since = 0;
        exp_v = done && !hold;
        if (exp_v) begin
            for (int k = 0; k < 4; k++)
                exp_o[k] = {mbuf[2*k], mbuf[2*k+1]} & 16'h3FFF;
        end
        byte_stb = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_stb = 1'b0;
        check_outs(req);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            since++;
            exp_v = 1'b0;
            check_outs(req);
        end
    endtask

    task automatic frame(input logic [7:0] seed, input logic [7:0] step, input string req);
        for (int k = 0; k < 8; k++) put(8'(seed + step * k), req);
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        since = 1000;   // long "idle" before the first byte: position zero anyway
        repeat (4) @(negedge clk);
        check_outs("R1");
        rst_n = 1'b1;
        idle(3, "R1");

        // R2: masking of top bits and byte order
        for (int k = 0; k < 8; k++) put(8'hFF, "R2");
        idle(2, "R3");
        frame(8'h00, 8'h00, "R2");
        frame(8'hC1, 8'h13, "R2");
        idle(1, "R3");

        // R8: back-to-back frames with several patterns
        for (int f = 0; f < 16; f++) frame(8'(f * 37), 8'(f * 11 + 3), "R8");
        idle(GAP + 2, "R4");

        // R5: sweep gap across the limit after a three-byte start
        for (int g = GAP - 2; g <= GAP + 2; g++) begin
            put(8'hA0, "R5"); put(8'h5B, "R5"); put(8'h3C, "R5");
            idle(g - 1, "R5");
            frame(8'(g * 5), 8'h29, "R5");
            idle(GAP + 3, "R5");
        end

        // R6: partial frames of every length are dropped on timeout
        for (int p = 1; p <= 7; p++) begin
            for (int k = 0; k < p; k++) put(8'(8'hE7 - k * p), "R6");
            idle(GAP + 1, "R6");
            frame(8'(p * 29), 8'h47, "R6");
        end

        // R5: very long idle is still one timeout
        idle(GAP * 40, "R5");
        put(8'h11, "R5"); put(8'h22, "R5");
        idle(GAP * 40, "R5");
        frame(8'h6D, 8'h0F, "R5");

        // R7: frozen frame is dropped, numbering continues
        hold = 1'b1;
        frame(8'h90, 8'h07, "R7");
        idle(2, "R7");
        hold = 1'b0;
        frame(8'h12, 8'h34, "R7");
        // R7: hold released before the last byte allows the update
        hold = 1'b1;
        for (int k = 0; k < 7; k++) put(8'(8'h40 + k), "R7");
        hold = 1'b0;
        put(8'h7F, "R7");
        // R7: hold raised only for the last byte blocks it
        for (int k = 0; k < 7; k++) put(8'(8'h80 + k * 9), "R7");
        hold = 1'b1;
        put(8'hEE, "R7");
        hold = 1'b0;
        frame(8'h05, 8'h61, "R8");
        idle(3, "R4");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule